// File: doc/BRIEF.md
# Glitch-free polarity-aware PWM channel

This block is one pulse-width modulation channel. A prescaler divides the system clock into ticks. A phase counter, advanced by those ticks, drives one pin. For the first part of each period the pin sits at the active level, and for the remainder it sits at the inactive level. The timing comes from three fields: a divider, an active-phase count and an inactive-phase count. A polarity bit chooses whether the active level is high or low. When the generator is idle, the pin rests at the inactive level of the polarity in force.

Settings are written with a one-cycle strobe. When the channel is idle, a write takes effect at once. While it runs, the write lands in a shadow set and waits for the end of the running period, so every period is built from one complete set of values. Dropping the enable never cuts a period short: the channel completes the period it is in, then stops and parks the pin. The settings in force can always be read back on dedicated outputs.

Top module: `pwm_glitchless`

## Requirements
- R1: After reset, `pwm_o` and `busy_o` are 0 and all read-back fields (`rb_div`, `rb_on`, `rb_off`, `rb_inv`) are 0.
- R2: While running with divider D, active count A and inactive count I, where A+I>0, one period lasts (A+I)*(D+1) clocks. The pin is active for the first A*(D+1) clocks of the period and inactive for the rest.
- R3: The active level is 1 when `rb_inv`=0 and 0 when `rb_inv`=1. The inactive level is always equal to `rb_inv`. While `busy_o`=0, the pin is held at the inactive level.
- R4: A write (`cfg_wr`=1) while `busy_o`=0 updates the read-back fields on the next cycle.
- R5: A write while `busy_o`=1 has no effect on the pin or on the read-back fields until the end of the running period. At that point the divider, both counts and the polarity are all replaced together. If a write coincides with the last clock of a period, it waits for the following period boundary.
- R6: When `run_en` is 0 on the last clock of a period, `busy_o` falls on the next cycle and the pin goes inactive. Dropping `run_en` earlier in the period does not shorten that period.
- R7: An active count of 0 keeps the pin inactive for the whole period. An inactive count of 0 with a nonzero active count keeps the pin active for the whole period. Neither case shows a single-clock spike.
- R8: When both counts are 0, the pin stays inactive and a period lasts D+1 clocks, so staged writes are applied after D+1 clocks.
- R9: While idle, `run_en`=1 at a clock edge sets `busy_o` on the next cycle, and the new period starts from its active phase.
- R10: The read-back fields always show the values in force, never values that are only staged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle strobe that writes the four setting fields |
| cfg_div | input | 8 | Prescaler divider; a tick every cfg_div+1 clocks |
| cfg_on | input | 8 | Active-phase length in ticks |
| cfg_off | input | 8 | Inactive-phase length in ticks |
| cfg_inv | input | 1 | Polarity: 1 makes the active level low |
| run_en | input | 1 | Level enable for the generator |
| pwm_o | output | 1 | Modulated output pin |
| busy_o | output | 1 | High while a period is running |
| rb_div | output | 8 | Divider in force |
| rb_on | output | 8 | Active count in force |
| rb_off | output | 8 | Inactive count in force |
| rb_inv | output | 1 | Polarity in force |

## Verification
Some properties are checked by assertions on every cycle. The prescaler count never passes the divider. The phase position stays inside the period. The settings in force change only at a period boundary or while idle. Busy can fall only right after a boundary. The pin shows the inactive level whenever the channel is idle, and a zero count pins the output to a single level.

The bench scenarios cover what the assertions cannot: exact period and duty lengths in clocks, the delay from a write to its effect, and the extra period that follows a late disable. A clock-accurate model built on clock counts within the period covers these, under random writes and enable toggling.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int DIV_W = 8;
  parameter int CNT_W = 8;
  localparam int POS_W = CNT_W + 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] on_cnt;
    logic [CNT_W-1:0] off_cnt;
    logic             inv;
  } pwm_cfg_t;

  // last tick position of a period; an empty period behaves as one tick
  function automatic logic [POS_W-1:0] last_pos(input logic [CNT_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
    logic [POS_W-1:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s == '0) ? '0 : s - POS_W'(1);
  endfunction

  function automatic logic in_active(input logic [POS_W-1:0] pos,
                                     input logic [CNT_W-1:0] on_cnt);
    return pos < {1'b0, on_cnt};
  endfunction

  function automatic logic drive_level(input logic act, input logic inv);
    return act ^ inv;
  endfunction
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;

  assign tick = run && (pre_q == div);

  always_ff @(posedge clk) begin
    if (!rst_n)             pre_q <= '0;
    else if (!run || tick)  pre_q <= '0;
    else                    pre_q <= pre_q + DIV_W'(1);
  end

  // R2: the divide count never runs past the divider in force
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_q <= div));

  // R2: a stopped prescaler restarts from zero
  p_pre_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));
endmodule

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  pwm_cfg_t wr_cfg,
  input  logic     run,
  input  logic     boundary,
  output pwm_cfg_t act_cfg
);
  pwm_cfg_t act_q, sh_q;
  logic     pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      sh_q   <= '0;
      pend_q <= 1'b0;
    end else if (!run) begin
      if (wr) begin
        act_q  <= wr_cfg;
        sh_q   <= wr_cfg;
        pend_q <= 1'b0;
      end
    end else begin
      if (boundary && pend_q) act_q <= sh_q;
      if (wr)                 sh_q  <= wr_cfg;
      pend_q <= boundary ? wr : (pend_q | wr);
    end
  end

  assign act_cfg = act_q;

  // R4: idle writes take effect on the next cycle
  p_idle_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr) |=> (act_q == $past(wr_cfg)));

  // R5, R10: the settings in force hold for the whole running period
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> $stable(act_q));

  // R5: a pending set is installed at the boundary
  p_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && boundary && pend_q) |=> (act_q == $past(sh_q)));
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase
  import pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_en,
  input  logic     tick,
  input  pwm_cfg_t act_cfg,
  output logic     run_o,
  output logic     boundary,
  output logic     pwm_o
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last;
  logic             run_q;
  logic             active;

  assign last     = last_pos(act_cfg.on_cnt, act_cfg.off_cnt);
  assign boundary = tick && (pos_q == last);
  assign active   = run_q && in_active(pos_q, act_cfg.on_cnt);
  assign pwm_o    = drive_level(active, act_cfg.inv);
  assign run_o    = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
    end else if (!run_q) begin
      run_q <= run_en;
      pos_q <= '0;
    end else if (tick) begin
      if (boundary) begin
        pos_q <= '0;
        if (!run_en) run_q <= 1'b0;
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  // R2: the position never leaves the period
  p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pos_q <= last));

  // R3: idle pin rests at the polarity-dependent inactive level
  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pwm_o == act_cfg.inv));

  // R6: the generator stops only right after a period boundary
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(boundary));

  // R7: zero active count never shows the active level
  p_zero_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && act_cfg.on_cnt == '0) |-> (pwm_o == act_cfg.inv));

  // R7: zero inactive count never shows the inactive level
  p_full_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && act_cfg.off_cnt == '0 && act_cfg.on_cnt != '0) |-> (pwm_o != act_cfg.inv));
endmodule

// File: rtl/pwm_glitchless.sv
module pwm_glitchless
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_on,
  input  logic [CNT_W-1:0] cfg_off,
  input  logic             cfg_inv,
  input  logic             run_en,
  output logic             pwm_o,
  output logic             busy_o,
  output logic [DIV_W-1:0] rb_div,
  output logic [CNT_W-1:0] rb_on,
  output logic [CNT_W-1:0] rb_off,
  output logic             rb_inv
);
  pwm_cfg_t wr_cfg, act_cfg;
  logic     run, tick, boundary;

  assign wr_cfg = '{div: cfg_div, on_cnt: cfg_on, off_cnt: cfg_off, inv: cfg_inv};

  pwm_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .div(act_cfg.div), .tick(tick)
  );

  pwm_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_cfg(wr_cfg),
    .run(run), .boundary(boundary), .act_cfg(act_cfg)
  );

  pwm_phase u_phase (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
    .act_cfg(act_cfg), .run_o(run), .boundary(boundary), .pwm_o(pwm_o)
  );

  assign busy_o = run;
  assign rb_div = act_cfg.div;
  assign rb_on  = act_cfg.on_cnt;
  assign rb_off = act_cfg.off_cnt;
  assign rb_inv = act_cfg.inv;

  // R9: an idle enable starts the generator on the next cycle
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && run_en) |=> busy_o);
endmodule

// File: tb/sim_pwm_glitchless.sv
`timescale 1ns/1ps
module sim_pwm_glitchless;
  import pwm_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_inv = 1'b0, run_en = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [CNT_W-1:0] cfg_on = '0, cfg_off = '0;
  logic pwm_o, busy_o, rb_inv;
  logic [DIV_W-1:0] rb_div;
  logic [CNT_W-1:0] rb_on, rb_off;

  always #5 clk = ~clk;

  pwm_glitchless u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
    .cfg_on(cfg_on), .cfg_off(cfg_off), .cfg_inv(cfg_inv), .run_en(run_en),
    .pwm_o(pwm_o), .busy_o(busy_o), .rb_div(rb_div), .rb_on(rb_on),
    .rb_off(rb_off), .rb_inv(rb_inv)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model state: clock index inside the running period
  int m_run = 0, m_c = 0, m_pend = 0;
  int a_div = 0, a_on = 0, a_off = 0, a_inv = 0;
  int s_div = 0, s_on = 0, s_off = 0, s_inv = 0;

  function automatic int per_clocks(int d, int on, int off);
    int ticks = (on + off == 0) ? 1 : on + off;
    return ticks * (d + 1);
  endfunction

  function automatic int exp_pin();
    bit act = (m_run != 0) && (m_c < a_on * (a_div + 1));
    return act ? (a_inv ^ 1) : a_inv;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(bit wr, bit en, int d, int on, int off, int inv, string tag);
    bit bnd;
    cfg_wr = wr; run_en = en; cfg_div = d[DIV_W-1:0];
    cfg_on = on[CNT_W-1:0]; cfg_off = off[CNT_W-1:0]; cfg_inv = inv[0];
    @(posedge clk);
    if (m_run == 0) begin
      if (wr) begin
        a_div = d; a_on = on; a_off = off; a_inv = inv;
        s_div = d; s_on = on; s_off = off; s_inv = inv; m_pend = 0;
      end
      if (en) begin m_run = 1; m_c = 0; end
    end else begin
      bnd = (m_c == per_clocks(a_div, a_on, a_off) - 1);
      if (bnd) begin
        if (m_pend != 0) begin a_div = s_div; a_on = s_on; a_off = s_off; a_inv = s_inv; end
        m_pend = wr; m_c = 0;
        if (!en) m_run = 0;
      end else begin
        m_c++;
        if (wr) m_pend = 1;
      end
      if (wr) begin s_div = d; s_on = on; s_off = off; s_inv = inv; end
    end
    @(negedge clk);
    chk(tag, "pwm_o", int'(pwm_o), exp_pin());
    chk(tag, "busy_o", int'(busy_o), m_run);
    chk(tag, "readback", {int'(rb_div), int'(rb_on), int'(rb_off), int'(rb_inv)} == {a_div, a_on, a_off, a_inv} ? 1 : 0, 1);
  endtask

  task automatic hold(int n, bit en, string tag);
    for (int i = 0; i < n; i++)
      step(1'b0, en, int'(cfg_div), int'(cfg_on), int'(cfg_off), int'(cfg_inv), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pwm_o", int'(pwm_o), 0);
    chk("R1", "busy_o", int'(busy_o), 0);
    chk("R1", "readback", int'(rb_div) + int'(rb_on) + int'(rb_off) + int'(rb_inv), 0);

    // R4 idle write applies at once; R3 idle level follows polarity
    step(1, 0, 1, 2, 3, 1, "R4");
    chk("R3", "idle level inverted", int'(pwm_o), 1);
    step(1, 0, 1, 2, 3, 0, "R4");
    chk("R3", "idle level normal", int'(pwm_o), 0);

    // R9 start; R2 periods with div=1, on=2, off=3 -> 10 clocks, 4 active
    step(0, 1, 1, 2, 3, 0, "R9");
    chk("R9", "busy after enable", int'(busy_o), 1);
    chk("R2", "first clock active", int'(pwm_o), 1);
    hold(25, 1, "R2");

    // R5 staged write mid-period, new polarity and timing together
    step(1, 1, 0, 1, 2, 1, "R5");
    chk("R10", "readback keeps old div", int'(rb_div), 1);
    hold(20, 1, "R5");

    // R7 zero active count and zero inactive count
    step(1, 1, 2, 0, 3, 0, "R7");
    hold(30, 1, "R7");
    step(1, 1, 1, 3, 0, 1, "R7");
    hold(30, 1, "R7");

    // R8 both counts zero
    step(1, 1, 3, 0, 0, 0, "R8");
    hold(12, 1, "R8");
    step(1, 1, 0, 2, 2, 0, "R8");
    hold(12, 1, "R8");

    // R6 drop enable early in a period: the period completes
    step(1, 1, 1, 2, 2, 1, "R6");
    hold(10, 1, "R6");
    hold(12, 0, "R6");
    chk("R6", "stopped", int'(busy_o), 0);
    chk("R6", "parked inactive (inverted)", int'(pwm_o), 1);

    // R5 random mix of writes and enable toggling
    for (int i = 0; i < 3000; i++) begin
      bit wr = ($urandom % 12) == 0;
      bit en = ($urandom % 40) != 0;
      step(wr, en, $urandom % 4, $urandom % 7, $urandom % 7, $urandom % 2, "R5");
    end
    hold(60, 0, "R6");
    chk("R6", "idle at end", int'(busy_o), 0);
    finish_run();
  end
endmodule